// File: doc/BRIEF.md
# Variable-Size DMA Descriptor Ring Sequencer

This block walks one DMA descriptor ring, either receive or transmit, chosen by a parameter. It holds the ring base and a configuration word, and keeps the address of the current descriptor. On a fetch request it sizes the descriptor from three configuration bits and reads that many 32-bit words over a word-read memory port. It holds the words and, when the last word has arrived, signals that the descriptor is ready and presents the buffer address.

On an advance request the current address moves to the next descriptor. It either steps past the descriptor just fetched or returns to the ring base when that descriptor carries its wrap flag. The descriptor size can change at run time between 2, 4 and 6 words. Both the fetch length and the stride follow it, and the length output tells the write-back logic how many words to return.

Top module: `desc_ring_seq`

## Requirements
- R1: The descriptor length in words is 2, plus 2 when config bit 30 (64-bit addressing) is set, plus 2 when the direction's extended bit is set: bit 28 for receive, bit 29 for transmit. The other direction's bit has no effect. The length is shown on desc_len_o, which resets to 2.
- R2: A fetch issues exactly desc_len_o word reads, at the current address plus 4*k for k = 0, 1 and upward in order. At most one read is accepted per cycle, and a read is accepted in a cycle where both mem_req_o and mem_gnt_i are high. Read data returns in order, qualified by mem_rvalid_i.
- R3: desc_valid_o pulses for exactly one cycle, the cycle after the last word returns. Word k sits in desc_o bits 32k+31:32k. Words beyond the length read as zero.
- R4: buf_addr_o bits 31:0 are word 0, with bits 1:0 cleared on receive and kept on transmit. Bits 63:32 are word 2 in 64-bit mode and zero otherwise.
- R5: The wrap flag is word 0 bit 1 on receive and word 1 bit 30 on transmit. When it is set, an advance loads the current address from the ring base.
- R6: When the wrap flag is clear, an advance adds 4 times the fetched length to the current address.
- R7: Writes to configuration bits 31, 27:25 and 15:12 are ignored, and those bits read as zero. All other bits are writable. The reset value is zero.
- R8: Writes to ring base bits 1:0 are ignored, and those bits read as zero. A base write while idle also loads the current address.
- R9: A configuration change made during a fetch does not alter the length or addressing mode of that fetch.
- R10: A fetch request, an advance or a pointer reload from a base write made while busy_o is high has no effect.
- R11: rx_buf_bytes_o equals config bits 23:16 times 64.
- R12: After reset the current address, base, config and desc_valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_o | output | 32 | Configuration readback |
| base_we_i | input | 1 | Ring base write strobe |
| base_wdata_i | input | AW | Ring base write data |
| base_o | output | AW | Ring base readback |
| fetch_req_i | input | 1 | Start fetching the current descriptor |
| adv_i | input | 1 | Step to the next descriptor |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | AW | Word read byte address |
| mem_gnt_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Fetch in progress |
| desc_valid_o | output | 1 | Descriptor ready pulse |
| desc_len_o | output | 3 | Words in the fetched descriptor |
| desc_o | output | 192 | Fetched descriptor words |
| buf_addr_o | output | 64 | Buffer address |
| cur_addr_o | output | AW | Current descriptor address |
| rx_buf_bytes_o | output | 14 | Receive buffer size in bytes |

## Verification
A wrong latched length shows on the first fetch after a configuration change. It appears as a wrong count of granted reads and a misplaced descriptor-valid pulse, and then as a wrong stride on the very next advance. A corrupted pointer or wrap decode appears on cur_addr_o one cycle after the advance, and on the read addresses of the following fetch. Stale or shifted word storage appears in desc_o and buf_addr_o in the cycle desc_valid_o rises. A leaked mid-fetch configuration change shows as an extra read or a stray upper address half.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned MAX_WORDS = 6;
  localparam int unsigned LEN_W     = $clog2(MAX_WORDS + 1);
  localparam int unsigned CNT_W     = LEN_W;
  // writable configuration bits: all except 31, 27:25, 15:12
  localparam logic [31:0] CFG_WR_MASK = 32'h71FF_0FFF;

  // sel = {addr64, tx_ext, rx_ext}
  function automatic logic [LEN_W-1:0] desc_words(input logic [2:0] sel, input logic is_rx);
    logic [LEN_W-1:0] n;
    n = LEN_W'(2);
    if (sel[2]) n = n + LEN_W'(2);
    if (is_rx ? sel[0] : sel[1]) n = n + LEN_W'(2);
    return n;
  endfunction
endpackage

// File: rtl/desc_cfg_regs.sv
module desc_cfg_regs #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  output logic [31:0]   cfg_o,
  output logic [AW-1:0] base_o
);
  import desc_ring_pkg::*;

  logic [31:0]   cfg_q;
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else begin
      if (cfg_we_i)  cfg_q  <= cfg_wdata_i & CFG_WR_MASK;
      if (base_we_i) base_q <= {base_wdata_i[AW-1:2], 2'b00};
    end
  end

  assign cfg_o  = cfg_q;
  assign base_o = base_q;

  assert_base_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> base_o[1:0] == 2'b00);
endmodule

// File: rtl/desc_addr_gen.sv
module desc_addr_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  input  logic             base_load_i,
  input  logic [AW-1:0]    base_wdata_i,
  input  logic [AW-1:0]    base_i,
  input  logic             adv_i,
  input  logic             wrap_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [AW-1:0]    cur_o
);
  logic [AW-1:0] cur_q, step;

  assign step = AW'({len_i, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cur_q <= '0;
    else if (!busy_i) begin
      if (base_load_i)              cur_q <= {base_wdata_i[AW-1:2], 2'b00};
      else if (adv_i)               cur_q <= wrap_i ? base_i : cur_q + step;
    end
  end

  assign cur_o = cur_q;

  assert_cur_aligned_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q[1:0] == 2'b00);
  assert_hold_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cur_q));
endmodule

// File: rtl/desc_fetch.sv
module desc_fetch #(
  parameter int unsigned AW    = 32,
  parameter bit          IS_RX = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [2:0]                sel_i,
  input  logic [AW-1:0]             cur_addr_i,
  output logic                      mem_req_o,
  output logic [AW-1:0]             mem_addr_o,
  input  logic                      mem_gnt_i,
  input  logic                      mem_rvalid_i,
  input  logic [31:0]               mem_rdata_i,
  output logic                      busy_o,
  output logic                      valid_o,
  output logic [desc_ring_pkg::LEN_W-1:0] len_o,
  output logic                      a64_o,
  output logic [desc_ring_pkg::MAX_WORDS-1:0][31:0] words_o
);
  import desc_ring_pkg::*;

  logic                              busy_q, valid_q, a64_q;
  logic [LEN_W-1:0]                  len_q;
  logic [CNT_W-1:0]                  issue_q, rcv_q;
  logic [MAX_WORDS-1:0][WORD_W-1:0]  words_q;
  logic                              last_rx;

  assign mem_req_o  = busy_q && (issue_q < len_q);
  assign mem_addr_o = cur_addr_i + AW'({issue_q, 2'b00});
  assign last_rx    = busy_q && mem_rvalid_i && (rcv_q == len_q - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      a64_q   <= 1'b0;
      len_q   <= LEN_W'(2);
      issue_q <= '0;
      rcv_q   <= '0;
      words_q <= '0;
    end else begin
      valid_q <= last_rx;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        len_q   <= desc_words(sel_i, IS_RX);
        a64_q   <= sel_i[2];
        issue_q <= '0;
        rcv_q   <= '0;
        words_q <= '0;
      end else if (busy_q) begin
        if (mem_req_o && mem_gnt_i) issue_q <= issue_q + CNT_W'(1);
        if (mem_rvalid_i) begin
          words_q[rcv_q] <= mem_rdata_i;
          rcv_q          <= rcv_q + CNT_W'(1);
        end
        if (last_rx) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = valid_q;
  assign len_o   = len_q;
  assign a64_o   = a64_q;
  assign words_o = words_q;

  assert_len_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (len_q == 3'd2 || len_q == 3'd4 || len_q == 3'd6));
  assert_issue_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (issue_q <= len_q && rcv_q <= issue_q));
  assert_valid_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_len_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || ($stable(len_q) && $stable(a64_q))));
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq #(
  parameter int unsigned AW    = 32,
  parameter bit          IS_RX = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_o,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_wdata_i,
  output logic [AW-1:0] base_o,
  input  logic          fetch_req_i,
  input  logic          adv_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          busy_o,
  output logic          desc_valid_o,
  output logic [2:0]    desc_len_o,
  output logic [191:0]  desc_o,
  output logic [63:0]   buf_addr_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [13:0]   rx_buf_bytes_o
);
  import desc_ring_pkg::*;

  logic [31:0]                      cfg;
  logic [AW-1:0]                    base, cur;
  logic                             busy, a64, wrap;
  logic [LEN_W-1:0]                 len;
  logic [MAX_WORDS-1:0][31:0]       words;
  logic [31:0]                      lo_mask;

  desc_cfg_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_wdata_i, .base_we_i, .base_wdata_i,
    .cfg_o(cfg), .base_o(base)
  );

  desc_fetch #(.AW(AW), .IS_RX(IS_RX)) u_fetch (
    .clk_i, .rst_ni,
    .start_i(fetch_req_i), .sel_i(cfg[30:28]), .cur_addr_i(cur),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .busy_o(busy), .valid_o(desc_valid_o), .len_o(len), .a64_o(a64), .words_o(words)
  );

  generate
    if (IS_RX) begin : g_rx
      assign wrap    = words[0][1];
      assign lo_mask = 32'hFFFF_FFFC;
    end else begin : g_tx
      assign wrap    = words[1][30];
      assign lo_mask = 32'hFFFF_FFFF;
    end
  endgenerate

  desc_addr_gen #(.AW(AW), .LEN_W(LEN_W)) u_addr (
    .clk_i, .rst_ni, .busy_i(busy),
    .base_load_i(base_we_i), .base_wdata_i(base_wdata_i), .base_i(base),
    .adv_i(adv_i), .wrap_i(wrap), .len_i(len), .cur_o(cur)
  );

  assign cfg_o          = cfg;
  assign base_o         = base;
  assign cur_addr_o     = cur;
  assign busy_o         = busy;
  assign desc_len_o     = len;
  assign desc_o         = words;
  assign buf_addr_o     = {a64 ? words[2] : 32'h0, words[0] & lo_mask};
  assign rx_buf_bytes_o = {cfg[23:16], 6'b0};

  assert_req_only_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_valid_after_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(desc_valid_o) |-> $fell(busy_o));
endmodule

// File: tb/test_desc_ring_seq.sv
module test_desc_ring_seq;
  localparam int AW = 32;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_we, base_we, gnt_off, gnt_slow;
  logic [31:0] cfg_wd, base_wd;
  logic rx_fetch, rx_adv, tx_fetch, tx_adv, gnt;
  logic [7:0] cyc;
  logic [31:0] mem [256];

  logic [31:0] rx_cfg, tx_cfg, rx_rdata, tx_rdata;
  logic [AW-1:0] rx_base, tx_base, rx_maddr, tx_maddr, rx_cur, tx_cur;
  logic rx_req, tx_req, rx_rvalid, tx_rvalid, rx_busy, tx_busy, rx_valid, tx_valid;
  logic [2:0] rx_len, tx_len;
  logic [191:0] rx_desc, tx_desc;
  logic [63:0] rx_buf, tx_buf;
  logic [13:0] rx_bytes, tx_bytes;

  desc_ring_seq #(.AW(AW), .IS_RX(1'b1)) i_desc_ring_seq (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_o(rx_cfg),
    .base_we_i(base_we), .base_wdata_i(base_wd), .base_o(rx_base),
    .fetch_req_i(rx_fetch), .adv_i(rx_adv), .mem_req_o(rx_req), .mem_addr_o(rx_maddr),
    .mem_gnt_i(gnt), .mem_rvalid_i(rx_rvalid), .mem_rdata_i(rx_rdata), .busy_o(rx_busy),
    .desc_valid_o(rx_valid), .desc_len_o(rx_len), .desc_o(rx_desc), .buf_addr_o(rx_buf),
    .cur_addr_o(rx_cur), .rx_buf_bytes_o(rx_bytes));

  desc_ring_seq #(.AW(AW), .IS_RX(1'b0)) i_desc_ring_seq_tx (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cfg_o(tx_cfg),
    .base_we_i(base_we), .base_wdata_i(base_wd), .base_o(tx_base),
    .fetch_req_i(tx_fetch), .adv_i(tx_adv), .mem_req_o(tx_req), .mem_addr_o(tx_maddr),
    .mem_gnt_i(gnt), .mem_rvalid_i(tx_rvalid), .mem_rdata_i(tx_rdata), .busy_o(tx_busy),
    .desc_valid_o(tx_valid), .desc_len_o(tx_len), .desc_o(tx_desc), .buf_addr_o(tx_buf),
    .cur_addr_o(tx_cur), .rx_buf_bytes_o(tx_bytes));

  // memory model: one-cycle read latency
  assign gnt = !gnt_off && (!gnt_slow || cyc[0]);
  always @(posedge clk) begin
    cyc       <= cyc + 8'd1;
    rx_rvalid <= rx_req && gnt;
    rx_rdata  <= mem[rx_maddr[9:2]];
    tx_rvalid <= tx_req && gnt;
    tx_rdata  <= mem[tx_maddr[9:2]];
  end

  int n_chk = 0, n_err = 0;
  task automatic chk(input logic ok, input string req, input logic [191:0] act, input logic [191:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard
  typedef struct { logic [191:0] d; logic [63:0] b; logic [2:0] len; string req; } exp_t;
  exp_t q_rx[$];
  int rx_seen = 0, rx_grants = 0;
  always @(negedge clk) begin
    if (rst_n && rx_req && gnt) rx_grants++;
    if (rst_n && rx_valid) begin
      if (q_rx.size() == 0) chk(1'b0, "R10 unexpected desc_valid", 192'(rx_valid), 192'(0));
      else begin
        exp_t e;
        e = q_rx.pop_front();
        chk(rx_len == e.len, {e.req, " R1 len"}, 192'(rx_len), 192'(e.len));
        chk(rx_desc == e.d, {e.req, " R3 words"}, rx_desc, e.d);
        chk(rx_buf == e.b, {e.req, " R4 buf"}, 192'(rx_buf), 192'(e.b));
      end
      rx_seen++;
    end
  end

  logic [31:0] m_cfg, m_base, m_cur, m_tcur;
  logic [2:0] m_len;
  logic m_wrap;

  function automatic logic [2:0] exp_len(input logic [31:0] c, input logic rx);
    return 3'd2 + (c[30] ? 3'd2 : 3'd0) + ((rx ? c[28] : c[29]) ? 3'd2 : 3'd0);
  endfunction

  task automatic pulse_rx_fetch(); @(negedge clk) rx_fetch = 1; @(negedge clk) rx_fetch = 0; endtask

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk) cfg_we = 1; cfg_wd = v;
    @(negedge clk) cfg_we = 0;
    m_cfg = v & 32'h71FF_0FFF;
  endtask

  task automatic wr_base(input logic [31:0] v);
    @(negedge clk) base_we = 1; base_wd = v;
    @(negedge clk) base_we = 0;
    m_base = {v[31:2], 2'b00}; m_cur = m_base; m_tcur = m_base;
  endtask

  task automatic rx_push(input string req);
    exp_t e;
    e.len = exp_len(m_cfg, 1'b1); e.d = '0; e.req = req;
    for (int k = 0; k < int'(e.len); k++) e.d[32*k +: 32] = mem[8'((m_cur >> 2) + k)];
    e.b = {m_cfg[30] ? e.d[95:64] : 32'h0, e.d[31:2], 2'b00};
    m_len = e.len; m_wrap = e.d[1];
    q_rx.push_back(e);
  endtask

  task automatic rx_wait(input int target);
    while (rx_seen < target) @(negedge clk);
  endtask

  task automatic rx_fetch_all(input string req);
    int g0, t;
    g0 = rx_grants; t = rx_seen + 1;
    rx_push(req);
    pulse_rx_fetch();
    rx_wait(t);
    chk(rx_grants - g0 == int'(m_len), "R2 read count", 192'(rx_grants - g0), 192'(m_len));
  endtask

  task automatic rx_advance(input string req);
    @(negedge clk) rx_adv = 1;
    @(negedge clk) rx_adv = 0;
    m_cur = m_wrap ? m_base : m_cur + 32'(m_len) * 4;
    chk(rx_cur == m_cur, req, 192'(rx_cur), 192'(m_cur));
  endtask

  task automatic tx_run(input string req);
    logic [2:0] l;
    logic [191:0] d;
    l = exp_len(m_cfg, 1'b0); d = '0;
    for (int k = 0; k < int'(l); k++) d[32*k +: 32] = mem[8'((m_tcur >> 2) + k)];
    @(negedge clk) tx_fetch = 1; @(negedge clk) tx_fetch = 0;
    while (!tx_valid) @(negedge clk);
    chk(tx_len == l, {req, " R1 tx len"}, 192'(tx_len), 192'(l));
    chk(tx_desc == d, {req, " R3 tx words"}, tx_desc, d);
    chk(tx_buf == {m_cfg[30] ? d[95:64] : 32'h0, d[31:0]}, {req, " R4 tx buf"}, 192'(tx_buf),
        192'({m_cfg[30] ? d[95:64] : 32'h0, d[31:0]}));
    @(negedge clk) tx_adv = 1;
    @(negedge clk) tx_adv = 0;
    m_tcur = d[62] ? m_base : m_tcur + 32'(l) * 4;
    chk(tx_cur == m_tcur, {req, " R5/R6 tx next"}, 192'(tx_cur), 192'(m_tcur));
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    int t;
    for (int i = 0; i < 256; i++) mem[i] = {2'b00, 6'(i), 8'h5A, 8'(i), 8'h01};
    rst_n = 0; cfg_we = 0; base_we = 0; cfg_wd = 0; base_wd = 0; cyc = 0;
    rx_fetch = 0; rx_adv = 0; tx_fetch = 0; tx_adv = 0; gnt_off = 0; gnt_slow = 0;
    m_cfg = 0; m_base = 0; m_cur = 0; m_tcur = 0; m_len = 2; m_wrap = 0;
    repeat (3) @(negedge clk);
    chk(rx_cur == 0 && rx_base == 0 && rx_cfg == 0, "R12 reset regs", 192'({rx_cur, rx_base, rx_cfg}), 192'(0));
    chk(rx_valid == 0 && rx_len == 3'd2, "R12 reset valid/len", 192'({rx_valid, rx_len}), 192'(2));
    rst_n = 1;

    wr_cfg(32'hFFFF_FFFF);
    chk(rx_cfg == 32'h71FF_0FFF, "R7 config mask", 192'(rx_cfg), 192'(32'h71FF_0FFF));
    chk(rx_bytes == 14'd16320, "R11 buffer bytes", 192'(rx_bytes), 192'(16320));
    wr_cfg(32'h0003_0000);
    chk(rx_bytes == 14'd192, "R11 buffer bytes 3", 192'(rx_bytes), 192'(192));

    wr_base(32'h0000_0043);
    chk(rx_base == 32'h40 && rx_cur == 32'h40, "R8 base align/load", 192'({rx_base, rx_cur}), 192'({32'h40, 32'h40}));

    wr_cfg(32'h0);
    rx_fetch_all("R1 base 2 words");
    rx_advance("R6 stride 8");
    gnt_slow = 1;
    wr_cfg(32'h4000_0000);
    rx_fetch_all("R4 64-bit 4 words");
    rx_advance("R6 stride 16");
    gnt_slow = 0;
    wr_cfg(32'h5000_0000);
    rx_fetch_all("R1 6 words");
    rx_advance("R6 stride 24");
    wr_cfg(32'h2000_0000);
    rx_fetch_all("R1 tx bit ignored on rx");
    rx_advance("R6 stride 8 again");

    // R9/R10: config change, advance and extra fetch during a stalled fetch
    wr_cfg(32'h0);
    gnt_off = 1;
    t = rx_seen + 1;
    rx_push("R9 mid-fetch config");
    pulse_rx_fetch();
    wr_cfg(32'h5000_0000);
    @(negedge clk) rx_adv = 1;
    @(negedge clk) rx_adv = 0;
    pulse_rx_fetch();
    chk(rx_cur == m_cur && rx_busy, "R10 advance ignored while busy", 192'(rx_cur), 192'(m_cur));
    gnt_off = 0;
    rx_wait(t);
    repeat (6) @(negedge clk);
    chk(rx_seen == t && !rx_busy, "R10 extra fetch ignored", 192'(rx_seen), 192'(t));
    rx_advance("R6 stride uses fetched length");

    // R5 wrap on receive: word0 bit1
    mem[8'(m_cur >> 2)] = 32'h0000_1236;
    rx_fetch_all("R5 rx wrap desc");
    chk(rx_buf[31:0] == 32'h1234, "R4 rx low bits cleared", 192'(rx_buf), 192'(32'h1234));
    rx_advance("R5 rx wrap to base");

    // transmit direction
    wr_base(32'h40);
    wr_cfg(32'h2000_0000);
    tx_run("R1 tx ext");
    chk(tx_buf[0] == 1'b1, "R4 tx low bits kept", 192'(tx_buf), 192'(mem[16]));
    mem[8'((m_tcur >> 2) + 1)] = 32'h4000_0000;
    wr_cfg(32'h6000_0000);
    tx_run("R5 tx wrap 6 words");
    chk(tx_cur == 32'h40, "R5 tx back at base", 192'(tx_cur), 192'(32'h40));

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule